// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and the calendar date in packed BCD: seconds, minutes, hours in 24-hour form, day of month, weekday, month and a two-digit year. It also keeps a century bit and a supply-low flag. A separate prescaler supplies a single-cycle enable once per second, and each enable advances the count by one second. The carries ripple up through every field in the same clock edge.

A register-style port can load any field directly and read any field back. While the port reports that an access is in progress, the count is frozen, so a multi-byte read always sees one coherent moment. One second tick that arrives during that window is kept and is applied as soon as the access ends. A halt input stops counting altogether.

Top module: `rtc_calendar_core`

## Requirements
- R1: Seconds and minutes count 00..59 and hours count 00..23 in BCD. One tick at 23:59:59 gives 00:00:00 and advances the day in that same clock edge.
- R2: Register offsets: 2h returns {low flag, seconds[6:0]}, 3h minutes, 4h {2'b0, hours}, 5h {2'b0, day}, 6h {5'b0, weekday}, 7h {century, 2'b0, month[4:0]}, 8h years. Any other offset reads 00h. rd_data is registered, so it is valid one clock edge after rd_addr.
- R3: A write with wr_en loads the addressed field from the low bits of wr_data. A write to an offset outside 2h..8h changes nothing. A tick in the same cycle as a write is held as pending.
- R4: At the last day of its month the day wraps to 01 and the month advances. April, June, September and November have 30 days, and the other months except February have 31. Month 12 wraps to 01 and the year advances.
- R5: February has 29 days when the binary value of the BCD year is a multiple of 4 (00 included), and 28 days otherwise.
- R6: When the year wraps from 99 to 00, the century bit (bit 7 at offset 7h) inverts. Writing offset 7h loads the century bit from wr_data[7].
- R7: The weekday counts 0..6 and advances at every day rollover, wrapping from 6 to 0.
- R8: A supply_low pulse sets the low flag (bit 7 at offset 2h). A write to offset 2h loads the flag from wr_data[7]. If both happen in one cycle, the pulse wins.
- R9: While access_busy is 1 the fields do not advance. If a tick arrives during that time, exactly one advance is applied in the first clock edge after access_busy falls, no matter how many ticks arrived.
- R10: While halt is 1 the fields do not advance. Ticks seen during halt are discarded, along with any pending tick.
- R11: Reset gives 00:00:00, day 01, month 01, year 00, weekday 0, century 0 and low flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle once-per-second enable |
| halt | input | 1 | Stops counting while 1 |
| access_busy | input | 1 | Register access in progress; freezes counting |
| supply_low | input | 1 | One-cycle low-supply event |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write offset |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | 8 | Registered read data |

## Verification
The hardest situations to reach are the deep carry paths. A leap-day or century rollover cannot be reached from reset in any reasonable number of ticks. The bench therefore writes each field directly to one second before the boundary and then issues a single tick. The frozen-access case is built the same way: access_busy is held high over several ticks, seconds is read while still frozen, and the count is then checked to have moved by exactly one after release.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam logic [3:0] OFS_SEC  = 4'h2;
  localparam logic [3:0] OFS_MIN  = 4'h3;
  localparam logic [3:0] OFS_HOUR = 4'h4;
  localparam logic [3:0] OFS_DAY  = 4'h5;
  localparam logic [3:0] OFS_WDAY = 4'h6;
  localparam logic [3:0] OFS_MON  = 4'h7;
  localparam logic [3:0] OFS_YEAR = 4'h8;

  // next BCD value of a two-digit field
  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last day of a month, in BCD
  function automatic logic [7:0] month_end(input logic [4:0] mon, input logic [7:0] yr);
    logic [6:0] ybin;
    ybin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    case (mon)
      5'h02: return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] q,
  output logic         wrap
);
  import rtc_cal_pkg::*;
  logic [7:0] nxt8;

  assign wrap = inc && (q == hi);
  assign nxt8 = bcd_next(8'(q));

  always_ff @(posedge clk) begin
    if (rst)       q <= RST_VAL;
    else if (ld)   q <= ld_val;
    else if (wrap) q <= lo;
    else if (inc)  q <= nxt8[W-1:0];
  end
endmodule

// File: rtl/rtc_tick_gate.sv
module rtc_tick_gate (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic halt,
  input  logic freeze,
  output logic step
);
  logic pend_q;

  assign step = !freeze && !halt && (tick || pend_q);

  always_ff @(posedge clk) begin
    if (rst)                 pend_q <= 1'b0;
    else if (halt)           pend_q <= 1'b0;
    else if (freeze && tick) pend_q <= 1'b1;
    else if (step)           pend_q <= 1'b0;
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              halt,
  input  logic              access_busy,
  input  logic              supply_low,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  import rtc_cal_pkg::*;

  localparam int NF = 6; // BCD fields: sec, min, hour, day, month, year
  localparam int FW [NF] = '{7, 7, 6, 6, 5, 8};
  localparam logic [3:0] FOFS [NF] = '{OFS_SEC, OFS_MIN, OFS_HOUR, OFS_DAY, OFS_MON, OFS_YEAR};
  localparam logic [7:0] FLO [NF] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00};

  logic       step;
  logic [7:0] fq   [NF];
  logic [7:0] fhi  [NF];
  logic       fwr  [NF];
  logic       finc [NF];
  logic [2:0] wday_q;
  logic       cent_q, low_q;

  rtc_tick_gate u_gate (
    .clk(clk), .rst(rst), .tick(sec_tick), .halt(halt),
    .freeze(access_busy || wr_en), .step(step)
  );

  assign fhi[0] = 8'h59;
  assign fhi[1] = 8'h59;
  assign fhi[2] = 8'h23;
  assign fhi[3] = month_end(fq[4][4:0], fq[5]);
  assign fhi[4] = 8'h12;
  assign fhi[5] = 8'h99;

  genvar g;
  generate
    for (g = 0; g < NF; g++) begin : g_fld
      logic [FW[g]-1:0] q;
      logic             wrap;
      if (g == 0) begin : g_first
        assign finc[g] = step;
      end else begin : g_chain
        assign finc[g] = g_fld[g-1].wrap;
      end
      rtc_bcd_field #(.W(FW[g]), .RST_VAL(FW[g]'(FLO[g]))) u_fld (
        .clk(clk), .rst(rst), .inc(finc[g]),
        .ld(wr_en && (wr_addr == ADDR_W'(FOFS[g]))),
        .ld_val(wr_data[FW[g]-1:0]),
        .lo(FW[g]'(FLO[g])), .hi(fhi[g][FW[g]-1:0]),
        .q(q), .wrap(wrap)
      );
      assign fq[g] = 8'(q);
    end
  endgenerate

  logic day_roll, year_roll, wr_wday, wr_mon, wr_sec;
  assign day_roll  = g_fld[2].wrap;
  assign year_roll = g_fld[5].wrap;
  assign wr_wday   = wr_en && (wr_addr == ADDR_W'(OFS_WDAY));
  assign wr_mon    = wr_en && (wr_addr == ADDR_W'(OFS_MON));
  assign wr_sec    = wr_en && (wr_addr == ADDR_W'(OFS_SEC));

  always_ff @(posedge clk) begin
    if (rst) begin
      wday_q <= 3'd0;
      cent_q <= 1'b0;
      low_q  <= 1'b1;
    end else begin
      if (wr_wday)       wday_q <= wr_data[2:0];
      else if (day_roll) wday_q <= (wday_q == 3'd6) ? 3'd0 : wday_q + 3'd1;
      if (wr_mon)         cent_q <= wr_data[7];
      else if (year_roll) cent_q <= ~cent_q;
      if (supply_low)  low_q <= 1'b1;
      else if (wr_sec) low_q <= wr_data[7];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else begin
      case (rd_addr)
        ADDR_W'(OFS_SEC):  rd_data <= {low_q, fq[0][6:0]};
        ADDR_W'(OFS_MIN):  rd_data <= fq[1];
        ADDR_W'(OFS_HOUR): rd_data <= fq[2];
        ADDR_W'(OFS_DAY):  rd_data <= fq[3];
        ADDR_W'(OFS_WDAY): rd_data <= {5'd0, wday_q};
        ADDR_W'(OFS_MON):  rd_data <= {cent_q, 2'b00, fq[4][4:0]};
        ADDR_W'(OFS_YEAR): rd_data <= fq[5];
        default:           rd_data <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk (
  input logic        clk,
  input logic        rst,
  input logic        sec_tick,
  input logic        halt,
  input logic        access_busy,
  input logic        supply_low,
  input logic        wr_en,
  input logic        step,
  input logic [47:0] fields,
  input logic        low_flag,
  input logic        cent,
  input logic        year_roll,
  input logic        wr_mon
);
  assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    (access_busy && !wr_en) |=> $stable(fields));

  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    ($fell(access_busy) && $past(sec_tick && !halt) && !halt && !wr_en) |-> step);

  assert_halt_R10: assert property (@(posedge clk) disable iff (rst)
    (halt && !wr_en) |=> $stable(fields));

  assert_low_set_R8: assert property (@(posedge clk) disable iff (rst)
    supply_low |=> low_flag);

  assert_century_R6: assert property (@(posedge clk) disable iff (rst)
    (year_roll && !wr_mon) |=> (cent != $past(cent)));
endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
  .clk(clk), .rst(rst), .sec_tick(sec_tick), .halt(halt),
  .access_busy(access_busy), .supply_low(supply_low), .wr_en(wr_en),
  .step(step),
  .fields({fq[0], fq[1], fq[2], fq[3], fq[4], fq[5]}),
  .low_flag(low_q), .cent(cent_q), .year_roll(year_roll), .wr_mon(wr_mon)
);

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_tick = 1'b0, halt = 1'b0, access_busy = 1'b0, supply_low = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  rtc_calendar_core u_dut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .halt(halt),
    .access_busy(access_busy), .supply_low(supply_low), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(posedge clk); #1 d = rd_data;
  endtask

  task automatic rd_chk(string tag, logic [3:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic one_tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic set_all(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] dd,
                         logic [7:0] wd, logic [7:0] mo, logic [7:0] y);
    wr(4'h2, s); wr(4'h3, m); wr(4'h4, h); wr(4'h5, dd);
    wr(4'h6, wd); wr(4'h7, mo); wr(4'h8, y);
  endtask

  task automatic test_reset();
    rd_chk("R11 sec+flag", 4'h2, 8'h80);
    rd_chk("R11 min", 4'h3, 8'h00);
    rd_chk("R11 hour", 4'h4, 8'h00);
    rd_chk("R11 day", 4'h5, 8'h01);
    rd_chk("R11 weekday", 4'h6, 8'h00);
    rd_chk("R11 month", 4'h7, 8'h01);
    rd_chk("R11 year", 4'h8, 8'h00);
  endtask

  task automatic test_regs();
    set_all(8'h12, 8'h34, 8'h15, 8'h27, 8'h05, 8'h08, 8'h42);
    rd_chk("R3 sec", 4'h2, 8'h12);
    rd_chk("R3 min", 4'h3, 8'h34);
    rd_chk("R3 hour", 4'h4, 8'h15);
    rd_chk("R3 month", 4'h7, 8'h08);
    wr(4'h9, 8'h55);
    rd_chk("R2 unmapped reads zero", 4'h9, 8'h00);
    rd_chk("R3 bad offset no effect", 4'h8, 8'h42);
    rd_chk("R2 offset 0 reads zero", 4'h0, 8'h00);
  endtask

  task automatic test_rollover();
    set_all(8'h59, 8'h59, 8'h23, 8'h15, 8'h03, 8'h06, 8'h24);
    one_tick();
    rd_chk("R1 sec wrap", 4'h2, 8'h00);
    rd_chk("R1 min wrap", 4'h3, 8'h00);
    rd_chk("R1 hour wrap", 4'h4, 8'h00);
    rd_chk("R1 day advance", 4'h5, 8'h16);
    rd_chk("R7 weekday advance", 4'h6, 8'h04);
    set_all(8'h09, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
    one_tick();
    rd_chk("R1 low digit carry", 4'h2, 8'h10);
  endtask

  task automatic test_months();
    set_all(8'h59, 8'h59, 8'h23, 8'h30, 8'h06, 8'h04, 8'h24);
    one_tick();
    rd_chk("R4 30-day month day", 4'h5, 8'h01);
    rd_chk("R4 30-day month next", 4'h7, 8'h05);
    rd_chk("R7 weekday 6 to 0", 4'h6, 8'h00);
    set_all(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h05, 8'h24);
    one_tick();
    rd_chk("R4 31-day month stays", 4'h5, 8'h31);
    set_all(8'h59, 8'h59, 8'h23, 8'h31, 8'h01, 8'h12, 8'h24);
    one_tick();
    rd_chk("R4 December wraps month", 4'h7, 8'h01);
    rd_chk("R4 year advances", 4'h8, 8'h25);
  endtask

  task automatic test_leap();
    set_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h24);
    one_tick();
    rd_chk("R5 leap Feb 29", 4'h5, 8'h29);
    set_all(8'h59, 8'h59, 8'h23, 8'h29, 8'h01, 8'h02, 8'h24);
    one_tick();
    rd_chk("R5 leap Feb 29 to Mar", 4'h7, 8'h03);
    set_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h23);
    one_tick();
    rd_chk("R5 common Feb day", 4'h5, 8'h01);
    rd_chk("R5 common Feb to Mar", 4'h7, 8'h03);
    set_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h00);
    one_tick();
    rd_chk("R5 year 00 is leap", 4'h5, 8'h29);
    set_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h10);
    one_tick();
    rd_chk("R5 year 10 not leap", 4'h5, 8'h01);
  endtask

  task automatic test_century();
    set_all(8'h59, 8'h59, 8'h23, 8'h31, 8'h01, 8'h12, 8'h99);
    one_tick();
    rd_chk("R6 year 99 to 00", 4'h8, 8'h00);
    rd_chk("R6 century set", 4'h7, 8'h81);
    wr(4'h7, 8'h82);
    rd_chk("R6 century write", 4'h7, 8'h82);
  endtask

  task automatic test_low_flag();
    wr(4'h2, 8'h05);
    rd_chk("R8 flag cleared", 4'h2, 8'h05);
    @(negedge clk); supply_low = 1'b1;
    @(negedge clk); supply_low = 1'b0;
    rd_chk("R8 flag set by pulse", 4'h2, 8'h85);
    @(negedge clk); supply_low = 1'b1; wr_en = 1'b1; wr_addr = 4'h2; wr_data = 8'h07;
    @(negedge clk); supply_low = 1'b0; wr_en = 1'b0;
    rd_chk("R8 pulse beats write", 4'h2, 8'h87);
  endtask

  task automatic test_freeze();
    set_all(8'h10, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
    @(negedge clk); access_busy = 1'b1;
    one_tick();
    one_tick();
    one_tick();
    rd_chk("R9 frozen during access", 4'h2, 8'h10);
    @(negedge clk); access_busy = 1'b0;
    rd_chk("R9 single pending applied", 4'h2, 8'h11);
    repeat (3) @(negedge clk);
    rd_chk("R9 no extra advance", 4'h2, 8'h11);
  endtask

  task automatic test_halt();
    set_all(8'h20, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
    @(negedge clk); halt = 1'b1;
    one_tick();
    rd_chk("R10 halted", 4'h2, 8'h20);
    @(negedge clk); halt = 1'b0;
    repeat (2) @(negedge clk);
    rd_chk("R10 tick discarded", 4'h2, 8'h20);
    one_tick();
    rd_chk("R10 resumes", 4'h2, 8'h21);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_regs();
    test_rollover();
    test_months();
    test_leap();
    test_century();
    test_low_flag();
    test_freeze();
    test_halt();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule